// File: doc/BRIEF.md
# Indirect Register Window

This block is a memory-mapped slave with two 32-bit bus locations. The location at offset 0x00 holds an index select register. The location at offset 0x10 is a data window. A read or write of the window reaches whichever internal register the select register currently names. The internal space has four kinds of register:

- an identification byte;
- a read-only version word that reports the highest pin number;
- a reserved word;
- a table of 64-bit redirection entries, one per interrupt pin. Software reaches each entry as two separately indexed 32-bit halves.

The whole table is presented in parallel on an output bus so that a dispatch engine can use it. Every write to an entry half raises a one-clock update pulse, which tells that engine to re-evaluate its pending pins. Dispatch itself and any save/restore of state live outside this block.

The bus has one write strobe and one read strobe. Read data is returned combinationally in the same cycle as the read strobe. Writes take effect at the clock edge that samples the write strobe.

Top module: `idxwin_top`

## Requirements
- R1: Only address bits 7:0 are decoded, so higher address bits are ignored. Offset 0x00 is the select register and offset 0x10 is the window. Any other offset reads zero, and a write to it changes no state and raises no update pulse.
- R2: The select register is 8 bits and is read and written at offset 0x00. A write takes data bits 7:0. A read returns the register in bits 7:0, with bits 31:8 zero.
- R3: Window index 0 is the identification register. A write stores data bits 31:24. A read returns the stored byte in bits 31:24 and zero elsewhere.
- R4: Window index 1 reads as 0x11 in bits 7:0 and the highest pin number (entries minus one, 23 by default) in bits 23:16, with zero elsewhere. A write to index 1 changes nothing.
- R5: Window index 2 reads zero, and a write to it changes nothing.
- R6: Window index 0x10+2n reaches bits 31:0 of entry n, and index 0x11+2n reaches bits 63:32 of entry n. Entry n appears on `tbl_flat` bits 64n+63 down to 64n.
- R7: A write to one half of an entry replaces that half and leaves the other 32 bits of the entry unchanged.
- R8: Window indices that map to no register read zero. These are 3 to 0x0F and every index from 0x10 plus twice the entry count upward. A write to such an index changes no state and raises no update pulse.
- R9: After reset, every entry equals 0x0000_0000_0001_0000 (mask bit 16 set, all other bits clear). The identification and select registers are zero and `tbl_upd` is low.
- R10: `tbl_upd` is high for exactly the one cycle that follows the clock edge that performed an entry-half write, and it is low at all other times.
- R11: `bus_rdata` carries the addressed value in the same cycle while `bus_rd` is high, and is zero while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; data is returned combinationally |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero while `bus_rd` is low |
| tbl_flat | output | NUM_ENTRIES*64 (1536) | All redirection entries, with entry n in bits 64n+63:64n |
| tbl_upd | output | 1 | One-cycle pulse after any entry-half write |

## Verification
Some behaviours are checked by assertions on every cycle:
- the update pulse follows each accepted entry-half write and never appears without one;
- a half write keeps the opposite half of that entry and leaves every unwritten entry untouched;
- the version word reads with its fixed contents whenever it is addressed;
- the select and identification registers capture the written bits.

Other behaviours can only be shown by the bench's scenarios:
- the reset values of the whole table;
- aliasing of the high address bits;
- reads of unmapped indices and of indices just past the end of the table;
- the interplay of select changes with later window accesses, under random mixes of reads and writes.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
   // decoded address bits and bus offsets
   localparam int          DEC_W     = 8;
   localparam int          SEL_W     = 8;
   localparam int          ID_W      = 8;
   localparam logic [7:0]  OFF_SEL   = 8'h00;
   localparam logic [7:0]  OFF_WIN   = 8'h10;
   // window indices
   localparam logic [7:0]  IDX_ID    = 8'h00;
   localparam logic [7:0]  IDX_VER   = 8'h01;
   localparam logic [7:0]  IDX_RSV   = 8'h02;
   localparam logic [7:0]  TBL_BASE  = 8'h10;
   localparam logic [7:0]  VER_CODE  = 8'h11;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_SEL,
      TGT_ID,
      TGT_VER,
      TGT_RSV,
      TGT_ENT_LO,
      TGT_ENT_HI
   } target_e;
endpackage

// File: rtl/idxwin_decode.sv
module idxwin_decode
   import idxwin_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int NUM_ENTRIES = 24,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEL_W-1:0]  sel,
   output target_e           tgt,
   output logic [IDX_W-1:0]  ent_idx
);
   localparam int TBL_END = 32'(TBL_BASE) + 2 * NUM_ENTRIES;

   logic [DEC_W-1:0] off;
   logic [SEL_W-1:0] rel;
   logic [SEL_W-1:0] slot;
   logic             in_tbl;

   if (TBL_END > (1 << SEL_W)) begin : g_bad_span
      $error("idxwin_decode: table does not fit the select range");
   end
   if (IDX_W > SEL_W) begin : g_bad_idx
      $error("idxwin_decode: entry index wider than select");
   end

   assign off     = addr[DEC_W-1:0];
   assign rel     = sel - TBL_BASE;
   assign slot    = rel >> 1;
   assign in_tbl  = (sel >= TBL_BASE) && (32'(slot) < NUM_ENTRIES);
   assign ent_idx = slot[IDX_W-1:0];

   always_comb begin
      tgt = TGT_NONE;
      if (off == OFF_SEL) begin
         tgt = TGT_SEL;
      end else if (off == OFF_WIN) begin
         if (sel == IDX_ID)       tgt = TGT_ID;
         else if (sel == IDX_VER) tgt = TGT_VER;
         else if (sel == IDX_RSV) tgt = TGT_RSV;
         else if (in_tbl)         tgt = sel[0] ? TGT_ENT_HI : TGT_ENT_LO;
      end
   end
endmodule

// File: rtl/idxwin_entry.sv
module idxwin_entry #(
   parameter int DATA_W   = 32,
   parameter int ENTRY_W  = 64,
   parameter int MASK_BIT = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic [DATA_W-1:0]  wdata,
   output logic [ENTRY_W-1:0] q
);
   localparam logic [ENTRY_W-1:0] RST_VAL = ENTRY_W'(1) << MASK_BIT;

   if (ENTRY_W != 2 * DATA_W) begin : g_bad_split
      $error("idxwin_entry: entry must be exactly two data words");
   end
   if (MASK_BIT >= ENTRY_W) begin : g_bad_mask
      $error("idxwin_entry: mask bit outside entry");
   end

   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= RST_VAL[DATA_W-1:0];
         hi_q <= RST_VAL[ENTRY_W-1:DATA_W];
      end else begin
         if (wr_lo) lo_q <= wdata;
         if (wr_hi) hi_q <= wdata;
      end
   end

   assign q = {hi_q, lo_q};

   a_r7_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (q[ENTRY_W-1:DATA_W] == $past(q[ENTRY_W-1:DATA_W])
                             && q[DATA_W-1:0] == $past(wdata)));
   a_r7_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (q[DATA_W-1:0] == $past(q[DATA_W-1:0])
                             && q[ENTRY_W-1:DATA_W] == $past(wdata)));
   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi) |=> $stable(q));
endmodule

// File: rtl/idxwin_rdmux.sv
module idxwin_rdmux
   import idxwin_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ENTRY_W     = 64,
   parameter int NUM_ENTRIES = 24,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic                                  rd_en,
   input  target_e                               tgt,
   input  logic [IDX_W-1:0]                      ent_idx,
   input  logic [SEL_W-1:0]                      sel,
   input  logic [ID_W-1:0]                       id,
   input  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0]   tbl,
   output logic [DATA_W-1:0]                     rdata
);
   localparam logic [7:0] MAX_PIN = 8'(NUM_ENTRIES - 1);

   logic [ENTRY_W-1:0] ent_sel;
   logic [DATA_W-1:0]  word;

   assign ent_sel = tbl[ent_idx];

   always_comb begin
      word = '0;
      unique case (tgt)
         TGT_SEL:    word[SEL_W-1:0]          = sel;
         TGT_ID:     word[DATA_W-1 -: ID_W]   = id;
         TGT_VER:    begin
                        word[7:0]   = VER_CODE;
                        word[23:16] = MAX_PIN;
                     end
         TGT_ENT_LO: word = ent_sel[DATA_W-1:0];
         TGT_ENT_HI: word = ent_sel[ENTRY_W-1:DATA_W];
         default:    word = '0;
      endcase
   end

   assign rdata = rd_en ? word : '0;
endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
   import idxwin_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int NUM_ENTRIES = 24,
   parameter int ENTRY_W     = 64,
   parameter int MASK_BIT    = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic                           bus_wr,
   input  logic                           bus_rd,
   input  logic [DATA_W-1:0]              bus_wdata,
   output logic [DATA_W-1:0]              bus_rdata,
   output logic [NUM_ENTRIES*ENTRY_W-1:0] tbl_flat,
   output logic                           tbl_upd
);
   localparam int IDX_W   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
   localparam int TBL_END = 32'(TBL_BASE) + 2 * NUM_ENTRIES;

   if (DATA_W != 32) begin : g_bad_dw
      $error("idxwin_top: data width must be 32");
   end
   if (ADDR_W < DEC_W) begin : g_bad_aw
      $error("idxwin_top: address narrower than decoded field");
   end
   if (NUM_ENTRIES < 1) begin : g_bad_n
      $error("idxwin_top: need at least one entry");
   end

   target_e          tgt;
   logic [IDX_W-1:0] ent_idx;
   logic [SEL_W-1:0] sel_q;
   logic [ID_W-1:0]  id_q;
   logic             upd_q;
   logic             wr_ent;
   logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] tbl;

   idxwin_decode #(
      .ADDR_W      (ADDR_W),
      .NUM_ENTRIES (NUM_ENTRIES)
   ) u_dec (
      .addr    (bus_addr),
      .sel     (sel_q),
      .tgt     (tgt),
      .ent_idx (ent_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
         upd_q <= 1'b0;
      end else begin
         if (bus_wr && tgt == TGT_SEL) sel_q <= bus_wdata[SEL_W-1:0];
         if (bus_wr && tgt == TGT_ID)  id_q  <= bus_wdata[DATA_W-1 -: ID_W];
         upd_q <= wr_ent;
      end
   end

   assign wr_ent = bus_wr && (tgt == TGT_ENT_LO || tgt == TGT_ENT_HI);

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      logic hit;
      assign hit = wr_ent && (ent_idx == IDX_W'(i));
      idxwin_entry #(
         .DATA_W   (DATA_W),
         .ENTRY_W  (ENTRY_W),
         .MASK_BIT (MASK_BIT)
      ) u_ent (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (hit && tgt == TGT_ENT_LO),
         .wr_hi (hit && tgt == TGT_ENT_HI),
         .wdata (bus_wdata),
         .q     (tbl[i])
      );
      assign tbl_flat[i*ENTRY_W +: ENTRY_W] = tbl[i];
   end

   idxwin_rdmux #(
      .DATA_W      (DATA_W),
      .ENTRY_W     (ENTRY_W),
      .NUM_ENTRIES (NUM_ENTRIES)
   ) u_rd (
      .rd_en   (bus_rd),
      .tgt     (tgt),
      .ent_idx (ent_idx),
      .sel     (sel_q),
      .id      (id_q),
      .tbl     (tbl),
      .rdata   (bus_rdata)
   );

   assign tbl_upd = upd_q;

   // assertions on port behaviour
   a_r10_upd_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[DEC_W-1:0] == OFF_WIN && sel_q >= TBL_BASE
       && 32'(sel_q) < TBL_END) |=> tbl_upd);
   a_r10_upd_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_upd |-> ($past(bus_wr) && $past(bus_addr[DEC_W-1:0]) == OFF_WIN));
   a_r4_version_word: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[DEC_W-1:0] == OFF_WIN && sel_q == IDX_VER)
      |-> bus_rdata == {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VER_CODE});
   a_r2_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[DEC_W-1:0] == OFF_SEL) |=> sel_q == $past(bus_wdata[SEL_W-1:0]));
   a_r3_id_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[DEC_W-1:0] == OFF_WIN && sel_q == IDX_ID)
      |=> id_q == $past(bus_wdata[DATA_W-1 -: ID_W]));
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);
endmodule

// File: tb/idxwin_top_tb_top.sv
module idxwin_top_tb_top;
   localparam int ADDR_W = 12;
   localparam int N      = 24;
   localparam int EW     = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [N*EW-1:0]   tbl_flat;
   logic              tbl_upd;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [7:0]  m_sel;
   logic [7:0]  m_id;
   logic [63:0] m_tbl [N];

   always #2.5 clk = ~clk;

   idxwin_top #(.ADDR_W(ADDR_W), .NUM_ENTRIES(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tbl_flat(tbl_flat), .tbl_upd(tbl_upd));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit ent_hit(input logic [7:0] s);
      return (s >= 8'h10) && (int'(s) < 16 + 2 * N);
   endfunction

   function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
      logic [7:0] off = a[7:0];
      if (off == 8'h00) return {24'h0, m_sel};
      if (off != 8'h10) return 32'h0;
      if (m_sel == 8'h00) return {m_id, 24'h0};
      if (m_sel == 8'h01) return {8'h00, 8'(N - 1), 8'h00, 8'h11};
      if (ent_hit(m_sel)) begin
         int n = (int'(m_sel) - 16) / 2;
         return m_sel[0] ? m_tbl[n][63:32] : m_tbl[n][31:0];
      end
      return 32'h0;
   endfunction

   task automatic model_reset();
      m_sel = 8'h00;
      m_id  = 8'h00;
      for (int i = 0; i < N; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
   endtask

   task automatic chk_table(input string req);
      for (int i = 0; i < N; i++) chk(req, tbl_flat[i*EW +: EW], m_tbl[i]);
   endtask

   // write, then check the update pulse in the cycle after the edge (R10)
   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      bit exp_upd = 1'b0;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      if (a[7:0] == 8'h00) m_sel = d[7:0];
      else if (a[7:0] == 8'h10) begin
         if (m_sel == 8'h00) m_id = d[31:24];
         else if (ent_hit(m_sel)) begin
            int n = (int'(m_sel) - 16) / 2;
            if (m_sel[0]) m_tbl[n][63:32] = d; else m_tbl[n][31:0] = d;
            exp_upd = 1'b1;
         end
      end
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R10 pulse", {63'h0, tbl_upd}, {63'h0, exp_upd});
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, input string req);
      @(negedge clk);
      chk("R10 idle", {63'h0, tbl_upd}, 64'h0);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      chk(req, {32'h0, bus_rdata}, {32'h0, exp_read(a)});
      bus_rd = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      int seed = 32'h1d3a;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk_table("R9 reset table");
      chk("R9 upd", {63'h0, tbl_upd}, 64'h0);
      bus_read(12'h000, "R9 sel reset");
      bus_read(12'h010, "R9 id reset");
      // R11 rd low gives zero
      bus_addr = 12'h000; #1;
      chk("R11 idle zero", {32'h0, bus_rdata}, 64'h0);
      // R2 select
      bus_write(12'h000, 32'hFFFF_FF01);
      bus_read(12'h000, "R2 sel bits");
      // R4 version and ignored write
      bus_read(12'h010, "R4 version");
      bus_write(12'h010, 32'hFFFF_FFFF);
      bus_read(12'h010, "R4 write ignored");
      // R3 id
      bus_write(12'h000, 32'h0);
      bus_write(12'h010, 32'hA5FF_FFFF);
      bus_read(12'h010, "R3 id");
      // R5 reserved
      bus_write(12'h000, 32'h2);
      bus_write(12'h010, 32'h1234_5678);
      bus_read(12'h010, "R5 reserved");
      // R6/R7 halves of entry 5 and last entry
      bus_write(12'h000, 32'h1A);
      bus_write(12'h010, 32'hDEAD_BEEF);
      bus_write(12'h000, 32'h1B);
      bus_write(12'h010, 32'hCAFE_F00D);
      bus_write(12'h000, 32'h1A);
      bus_write(12'h010, 32'h0000_1111);
      chk("R7 keep high", tbl_flat[5*EW +: EW], 64'hCAFE_F00D_0000_1111);
      bus_read(12'h010, "R6 low read");
      bus_write(12'h000, 32'h3F);
      bus_write(12'h010, 32'h7777_0000);
      chk("R6 last entry", tbl_flat[23*EW +: EW], 64'h7777_0000_0001_0000);
      // R8 unmapped indices
      bus_write(12'h000, 32'h05);
      bus_write(12'h010, 32'hFFFF_FFFF);
      bus_read(12'h010, "R8 index 5");
      bus_write(12'h000, 32'h40);
      bus_write(12'h010, 32'hFFFF_FFFF);
      bus_read(12'h010, "R8 past end");
      chk_table("R8 no change");
      // R1 aliasing and other offsets
      bus_write(12'h300, 32'h21);
      bus_read(12'h000, "R1 alias sel");
      bus_write(12'hF10, 32'h5555_AAAA);
      bus_read(12'h110, "R1 alias win");
      bus_write(12'h004, 32'hFFFF_FFFF);
      bus_read(12'h004, "R1 other offset");
      bus_read(12'h000, "R1 sel unchanged");
      chk_table("R1 table");
      // random mix
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 5);
         logic [ADDR_W-1:0] hi = ADDR_W'($urandom_range(0, 15)) << 8;
         logic [7:0] s = ($urandom_range(0, 3) == 0) ? 8'($urandom()) :
                         8'($urandom_range(0, 16 + 2 * N + 1));
         case (op)
            0: bus_write(hi | 12'h000, {24'($urandom()), s});
            1, 2: bus_write(hi | 12'h010, $urandom());
            3: bus_read(hi | 12'h010, "R6 random read");
            4: bus_read(hi | 12'h000, "R2 random read");
            default: bus_write(hi | ADDR_W'($urandom_range(0, 255)), $urandom());
         endcase
         if (it % 40 == 0) chk_table("R7 random table");
      end
      chk_table("R7 final table");
      // reset again mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; model_reset();
      @(negedge clk);
      chk_table("R9 re-reset");
      bus_read(12'h000, "R9 sel re-reset");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule